// File: doc/BRIEF.md
# Pushbutton Power State Controller

This block sequences a system through four power states (down, off, up and on) in response to a momentary pushbutton, a power-on request from the host, and a power-good flag from an always-on supply. It drives a wake enable, which is normally wired to the first regulator of a start-up chain, and an active-low reset status for the rest of the system. All intervals are counted in milliseconds, which a prescaler derives from a free-running tick input.

After a power-on reset the controller waits one second in the down state with reset status held low, then rests in the off state. From off, a continuous button press of 400 ms or a host power-on request starts the up phase and raises wake. The host then has a fixed five-second window to confirm by holding its power-on request high. If it does, the controller settles in the on state. If it does not, the controller drops wake and returns to the down state. From on, the host can drop its request, or the user can hold the button for five seconds to force a hard reset. Either one returns the controller to the down state. A parameter selects a variant that leaves reset directly in the off state.

Top module: `pushbutton_power_ctrl`

## Requirements
- R1: While power-on reset is asserted, and directly after it is released, wake_o is 0 and rst_stat_n_o is 0. The default variant starts in the down state.
- R2: The down state lasts T_PDN_MS milliseconds and then gives way to the off state. rst_stat_n_o is 1 only when the state is not down and the synchronized power-good is 1.
- R3: With BOOT_TO_OFF=1 the controller resets into the off state, so rst_stat_n_o rises as soon as power-good reaches it through the synchronizer.
- R4: From off, a continuous button-low press lasting T_PB_MS milliseconds moves the controller to the up state.
- R5: From off, a high pwr_on_i moves the controller to the up state.
- R6: wake_o is 1 exactly while the state is up or on.
- R7: The up state lasts T_PUP_MS milliseconds. If pwr_on_i is high when it ends, the controller moves to on and wake_o stays 1.
- R8: If pwr_on_i is low when the up window ends, the controller goes straight back to the down state without dwelling in on. wake_o falls and a new down-state interval starts.
- R9: In the on state, a low pwr_on_i sends the controller to the down state.
- R10: In the on state, a continuous button-low press lasting T_HARD_MS milliseconds sends the controller to the down state, even while pwr_on_i is high.
- R11: The button-hold count returns to zero whenever the synchronized button is high, so separate short presses never add up.
- R12: btn_n_i, pwr_on_i and pgood_i each pass through two flip-flops before use. One millisecond elapses per PRESCALE tick_i pulses, and without ticks no timer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| tick_i | input | 1 | Timebase pulse, PRESCALE pulses per millisecond |
| btn_n_i | input | 1 | Pushbutton, active low, asynchronous |
| pwr_on_i | input | 1 | Host power-on request / confirmation, asynchronous |
| pgood_i | input | 1 | Always-on supply power good, asynchronous |
| wake_o | output | 1 | Wake enable for the start-up chain |
| rst_stat_n_o | output | 1 | Active-low reset status |

## Verification
The bench makes two button presses that are each shorter than the threshold, separated by a release. A design that accumulated hold time across the release would raise wake after the second press. It lets the up window expire with no confirmation, which catches a design that stays on or keeps wake high. It forces a hard reset with the power-on request held high, which a design that checks only the request line would ignore. It also stops the tick stream while the button is held, and a design that counted clocks instead of ticks would wake during that pause. Both variants run side by side, so a wrong reset state or an early release of reset status shows up immediately.

// File: rtl/pbpc_pkg.sv
package pbpc_pkg;

  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_OFF  = 2'd1,
    PS_UP   = 2'd2,
    PS_ON   = 2'd3
  } pstate_t;

  // Wake is released in the two powered states.
  function automatic logic is_awake(input pstate_t s);
    return (s == PS_UP) || (s == PS_ON);
  endfunction

  // Transition rule; timer and hold flags are already thresholded.
  function automatic pstate_t next_state(
    input pstate_t s,
    input logic    tmr_done,
    input logic    pb_short,
    input logic    pb_long,
    input logic    pwron
  );
    pstate_t n;
    n = s;
    case (s)
      PS_DOWN: if (tmr_done) n = PS_OFF;
      PS_OFF:  if (pb_short || pwron) n = PS_UP;
      PS_UP:   if (tmr_done) n = pwron ? PS_ON : PS_DOWN;
      PS_ON:   if (!pwron || pb_long) n = PS_DOWN;
      default: n = PS_DOWN;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pbpc_sync.sv
module pbpc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         por_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pbpc_prescale.sv
module pbpc_prescale #(
  parameter int PRESCALE = 1000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic tick_i,
  output logic ms_stb_o
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;
  logic          stb_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        stb_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        stb_q <= 1'b0;
      end
    end else begin
      stb_q <= 1'b0;
    end
  end

  assign ms_stb_o = stb_q;
endmodule

// File: rtl/pbpc_ms_counter.sv
// Saturating millisecond counter with synchronous clear.
module pbpc_ms_counter #(
  parameter int LIMIT = 5000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          por_i,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                       cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (step_i && cnt_q < TOP)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pushbutton_power_ctrl.sv
module pushbutton_power_ctrl
  import pbpc_pkg::*;
#(
  parameter int PRESCALE    = 1000,
  parameter int T_PDN_MS    = 1000,
  parameter int T_PB_MS     = 400,
  parameter int T_PUP_MS    = 5000,
  parameter int T_HARD_MS   = 5000,
  parameter bit BOOT_TO_OFF = 1'b0
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic tick_i,
  input  logic btn_n_i,
  input  logic pwr_on_i,
  input  logic pgood_i,
  output logic wake_o,
  output logic rst_stat_n_o
);
  localparam int TMR_LIM  = (T_PDN_MS > T_PUP_MS) ? T_PDN_MS : T_PUP_MS;
  localparam int HOLD_LIM = (T_HARD_MS > T_PB_MS) ? T_HARD_MS : T_PB_MS;
  localparam int TW       = $clog2(TMR_LIM + 1);
  localparam int HW       = $clog2(HOLD_LIM + 1);
  localparam pstate_t RESET_STATE = BOOT_TO_OFF ? PS_OFF : PS_DOWN;

  // Synchronized inputs: bit0 button (idle high), bit1 request, bit2 power good.
  logic [2:0] raw_in, syn_in;
  logic       btn_s, pwron_s, pgood_s;

  assign raw_in = {pgood_i, pwr_on_i, btn_n_i};

  pbpc_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .por_i (por_i),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign btn_s   = syn_in[0];
  assign pwron_s = syn_in[1];
  assign pgood_s = syn_in[2];

  logic ms_stb;

  pbpc_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .tick_i   (tick_i),
    .ms_stb_o (ms_stb)
  );

  // Button hold time; restarts on any release.
  logic [HW-1:0] hold_cnt;
  logic          pb_short, pb_long, hold_idle;

  pbpc_ms_counter #(.LIMIT(HOLD_LIM)) u_hold (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .clr_i  (btn_s),
    .step_i (ms_stb),
    .cnt_o  (hold_cnt)
  );

  assign pb_short  = (hold_cnt >= HW'(T_PB_MS));
  assign pb_long   = (hold_cnt >= HW'(T_HARD_MS));
  assign hold_idle = (hold_cnt == '0);

  // State timer; restarts on each state change.
  pstate_t       state_q, state_nxt;
  logic          state_chg, tmr_done;
  logic [TW-1:0] tmr_cnt;

  pbpc_ms_counter #(.LIMIT(TMR_LIM)) u_tmr (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .clr_i  (state_chg),
    .step_i (ms_stb),
    .cnt_o  (tmr_cnt)
  );

  always_comb begin
    case (state_q)
      PS_DOWN: tmr_done = (tmr_cnt >= TW'(T_PDN_MS));
      PS_UP:   tmr_done = (tmr_cnt >= TW'(T_PUP_MS));
      default: tmr_done = 1'b0;
    endcase
  end

  assign state_nxt = next_state(state_q, tmr_done, pb_short, pb_long, pwron_s);
  assign state_chg = (state_nxt != state_q);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) state_q <= RESET_STATE;
    else       state_q <= state_nxt;
  end

  assign wake_o       = is_awake(state_q);
  assign rst_stat_n_o = (state_q != PS_DOWN) && pgood_s;
endmodule

// File: rtl/pbpc_checker.sv
module pbpc_checker
  import pbpc_pkg::*;
(
  input logic    clk_i,
  input logic    por_i,
  input pstate_t state_q,
  input logic    tmr_done,
  input logic    pb_short,
  input logic    pb_long,
  input logic    pwron_s,
  input logic    btn_s,
  input logic    hold_idle,
  input logic    wake_o,
  input logic    rst_stat_n_o
);
  AST_DOWN_HOLDS: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_DOWN && !tmr_done) |=> (state_q == PS_DOWN)); // R2

  AST_DOWN_RST_LOW: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_DOWN) |-> !rst_stat_n_o); // R2

  AST_OFF_STAYS: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_OFF && !pb_short && !pwron_s) |=> (state_q == PS_OFF)); // R4

  AST_OFF_WAKES: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_OFF && pwron_s) |=> wake_o); // R5

  AST_UP_CONFIRM: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_UP && tmr_done && pwron_s) |=> (state_q == PS_ON)); // R7

  AST_WAKE_DROP_DOWN: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(wake_o) |-> (state_q == PS_DOWN)); // R8

  AST_ON_REQ_LOW: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_ON && !pwron_s) |=> (state_q == PS_DOWN)); // R9

  AST_ON_HARD: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == PS_ON && pb_long) |=> (state_q == PS_DOWN)); // R10

  AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (por_i)
    btn_s |=> hold_idle); // R11
endmodule

bind pushbutton_power_ctrl pbpc_checker u_chk (
  .clk_i        (clk_i),
  .por_i        (por_i),
  .state_q      (state_q),
  .tmr_done     (tmr_done),
  .pb_short     (pb_short),
  .pb_long      (pb_long),
  .pwron_s      (pwron_s),
  .btn_s        (btn_s),
  .hold_idle    (hold_idle),
  .wake_o       (wake_o),
  .rst_stat_n_o (rst_stat_n_o)
);

// File: tb/pushbutton_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module pushbutton_power_ctrl_tb_top;
  localparam int PRE = 3, TPDN = 10, TPB = 6, TPUP = 20, THARD = 15;

  logic clk = 1'b0, por = 1'b1, tick = 1'b0, tick_en = 1'b0;
  logic btn_n = 1'b1, pwr_on = 1'b0, pgood = 1'b0;
  logic wake_a, rst_a, wake_b, rst_b;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pushbutton_power_ctrl #(.PRESCALE(PRE), .T_PDN_MS(TPDN), .T_PB_MS(TPB),
    .T_PUP_MS(TPUP), .T_HARD_MS(THARD), .BOOT_TO_OFF(1'b0)) dut_i (
    .clk_i(clk), .por_i(por), .tick_i(tick), .btn_n_i(btn_n),
    .pwr_on_i(pwr_on), .pgood_i(pgood), .wake_o(wake_a), .rst_stat_n_o(rst_a));

  pushbutton_power_ctrl #(.PRESCALE(PRE), .T_PDN_MS(TPDN), .T_PB_MS(TPB),
    .T_PUP_MS(TPUP), .T_HARD_MS(THARD), .BOOT_TO_OFF(1'b1)) dut_off_i (
    .clk_i(clk), .por_i(por), .tick_i(tick), .btn_n_i(btn_n),
    .pwr_on_i(pwr_on), .pgood_i(pgood), .wake_o(wake_b), .rst_stat_n_o(rst_b));

  always @(negedge clk) tick <= tick_en ? ~tick : 1'b0;

  // Reference model: 0=down 1=off 2=up 3=on; index 0 default, 1 boot-to-off.
  int bq[$], pq[$], gq[$];
  int m_pre, m_ms, m_hold;
  int m_st[2], m_tm[2];

  function automatic int lim_of(int st);
    return (st == 0) ? TPDN : (st == 2) ? TPUP : 0;
  endfunction

  always @(posedge clk or posedge por) begin
    if (por) begin
      bq = '{1, 1}; pq = '{0, 0}; gq = '{0, 0};
      m_pre = 0; m_ms = 0; m_hold = 0;
      m_st[0] = 0; m_st[1] = 1; m_tm[0] = 0; m_tm[1] = 0;
    end else begin
      int b, p, ms, hold, ns;
      b = bq[1]; p = pq[1]; ms = m_ms; hold = m_hold;
      for (int v = 0; v < 2; v++) begin
        int st, tm, fin;
        st = m_st[v]; tm = m_tm[v];
        fin = (st == 0 || st == 2) && (tm >= lim_of(st));
        ns = st;
        if (st == 0 && fin) ns = 1;
        else if (st == 1 && (hold >= TPB || p != 0)) ns = 2;
        else if (st == 2 && fin) ns = (p != 0) ? 3 : 0;
        else if (st == 3 && (p == 0 || hold >= THARD)) ns = 0;
        if (ns != st) m_tm[v] = 0;
        else if (ms != 0 && tm < TPUP) m_tm[v] = tm + 1;
        m_st[v] = ns;
      end
      if (b != 0) m_hold = 0;
      else if (ms != 0 && hold < THARD) m_hold = hold + 1;
      m_ms = 0;
      if (tick) begin
        if (m_pre == PRE - 1) begin m_pre = 0; m_ms = 1; end
        else m_pre = m_pre + 1;
      end
      void'(bq.pop_back()); bq.push_front(int'(btn_n));
      void'(pq.pop_back()); pq.push_front(int'(pwr_on));
      void'(gq.pop_back()); gq.push_front(int'(pgood));
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R6 wake, R2/R3 reset status).
  always @(negedge clk) begin
    if (!por && !done) begin
      int ew_a, ew_b, er_a, er_b;
      ew_a = (m_st[0] >= 2); ew_b = (m_st[1] >= 2);
      er_a = (m_st[0] != 0 && gq[1] != 0); er_b = (m_st[1] != 0 && gq[1] != 0);
      chk(int'(wake_a) == ew_a, "R6 model wake default", int'(wake_a), ew_a);
      chk(int'(wake_b) == ew_b, "R6 model wake boot-off", int'(wake_b), ew_b);
      chk(int'(rst_a) == er_a, "R2 model rst_stat default", int'(rst_a), er_a);
      chk(int'(rst_b) == er_b, "R3 model rst_stat boot-off", int'(rst_b), er_b);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk(wake_a == 1'b0 && rst_a == 1'b0, "R1 during reset", int'({wake_a, rst_a}), 0);
    por = 1'b0; tick_en = 1'b1;
    cyc(1);
    chk(wake_a == 1'b0 && rst_a == 1'b0, "R1 after reset", int'({wake_a, rst_a}), 0);
    pgood = 1'b1;
    cyc(4);
    chk(rst_b == 1'b1, "R3 boot-off releases on power good", int'(rst_b), 1);
    chk(rst_a == 1'b0, "R2 default held in down", int'(rst_a), 0);
    cyc(100);
    chk(rst_a == 1'b1, "R2 down expired to off", int'(rst_a), 1);
    // R11: two short presses separated by a release
    btn_n = 1'b0; cyc(18); btn_n = 1'b1; cyc(12);
    btn_n = 1'b0; cyc(18); btn_n = 1'b1; cyc(8);
    chk(wake_a == 1'b0, "R11 short presses do not add up", int'(wake_a), 0);
    // R4: long continuous press
    btn_n = 1'b0; cyc(60); btn_n = 1'b1;
    chk(wake_a == 1'b1 && wake_b == 1'b1, "R4 long press wakes", int'({wake_a, wake_b}), 3);
    // R8: no confirmation within the up window
    cyc(150);
    chk(wake_a == 1'b0 && rst_a == 1'b0, "R8 unconfirmed returns to down", int'({wake_a, rst_a}), 0);
    cyc(100);
    chk(rst_a == 1'b1, "R8 down interval restarted then off", int'(rst_a), 1);
    // R5 and R7: request wakes, confirmation keeps it on
    pwr_on = 1'b1; cyc(10);
    chk(wake_a == 1'b1, "R5 request wakes from off", int'(wake_a), 1);
    cyc(150);
    chk(wake_a == 1'b1, "R7 confirmed stays on", int'(wake_a), 1);
    // R9: request drop from on
    pwr_on = 1'b0; cyc(10);
    chk(wake_a == 1'b0 && rst_a == 1'b0, "R9 request drop to down", int'({wake_a, rst_a}), 0);
    cyc(100);
    // R10: hard reset with request held high
    pwr_on = 1'b1; cyc(150);
    chk(wake_a == 1'b1, "R10 precondition on", int'(wake_a), 1);
    btn_n = 1'b0; cyc(110);
    chk(wake_a == 1'b0 && rst_a == 1'b0, "R10 hard reset to down", int'({wake_a, rst_a}), 0);
    btn_n = 1'b1; pwr_on = 1'b0;
    cyc(100);
    chk(wake_a == 1'b0 && rst_a == 1'b1, "R10 back in off", int'({wake_a, rst_a}), 1);
    // R12: no ticks, no timing
    tick_en = 1'b0; cyc(2);
    btn_n = 1'b0; cyc(120);
    chk(wake_a == 1'b0 && wake_b == 1'b0, "R12 frozen without ticks", int'({wake_a, wake_b}), 0);
    btn_n = 1'b1; tick_en = 1'b1; cyc(20);
    finish_run();
  end
endmodule